// File: doc/BRIEF.md
# Noise-Tolerant Multiplier Wrapper

This block multiplies two unsigned 12-bit operands. It runs two multipliers side by side on the same registered operands. The main path forms the full 24-bit product. A small shadow multiplier sees only the top six bits of each operand and produces a six-bit fixed-width estimate of the product's upper part. That estimate is placed at the top of a 24-bit word and used as a trusted fallback.

Each sample, the block forms the magnitude of the difference between the main product and the aligned estimate. It compares that magnitude with a threshold supplied alongside the operands. If the magnitude is within the threshold, the exact product is sent out. If it exceeds the threshold, the main result is taken to be corrupted, and the estimate is sent out together with a flag.

A debug mask is XORed into the main product before the comparison, so a bench can fake timing faults in the main path.

There is no multi-state control. The choice of source is an enumerated value with two states:
- MAIN_SRC is chosen when the magnitude is at most the threshold.
- SHADOW_SRC is chosen when the magnitude is greater than the threshold.

Every sample makes this choice afresh, with no memory between samples.

Top module: `noise_tolerant_mul`

## Requirements
- R1: A synchronous active-high reset forces the product output and the flag to zero at the next rising edge.
- R2: With a zero mask and a threshold of 24'hFFFFFF, the output equals the exact unsigned product of the operands and the flag is 0.
- R3: The estimate is computed from the top six bits of each operand, A[11:6] and B[11:6]. With partial products p(i,j) = A[6+i] & B[6+j]:
  - each p(i,j) with i+j >= 6 adds 2^(i+j-6);
  - each p(i,j) with i+j == 5 adds 1;
  - the sum saturates at 63.

  The six-bit estimate is then shifted left by 18, so bits 17:0 are zero.
- R4: The difference magnitude is correct whether the main product is above or below the aligned estimate.
- R5: When the magnitude equals the threshold, the main value is output. When the magnitude is one greater than the threshold, the aligned estimate is output.
- R6: The mask is XORed into the main product before the comparison. When the main path is selected, the masked value is what appears at the output.
- R7: Operands, threshold and mask are captured at one rising edge, and the result appears after the next rising edge. A new sample may be applied every cycle.
- R8: The flag is 1 exactly when the output carries the aligned estimate.
- R9: The low six bits of each operand have no effect on the estimate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 12 | Unsigned operand A |
| op_b | input | 12 | Unsigned operand B |
| thresh | input | 24 | Unsigned tolerance on the difference magnitude |
| dbg_mask | input | 24 | XOR mask applied to the main product |
| prod | output | 24 | Registered selected product |
| rep_used | output | 1 | Registered flag: 1 when the estimate was selected |

## Verification
Every result is due two rising edges after its inputs are driven. The first edge captures the inputs and the second registers the selection. For single-sample tests, the bench drives at a falling edge, waits two rising edges and samples at the following falling edge. In the streaming test, the bench drives a new sample at each falling edge and checks the sample it drove two falling edges earlier. A reset applied mid-run is checked at the falling edge after the single rising edge on which it is held.

// File: rtl/ntm_pkg.sv
package ntm_pkg;

    localparam int OP_W_DEFAULT  = 12;
    localparam int REP_W_DEFAULT = 6;

    typedef enum logic {
        MAIN_SRC   = 1'b0,
        SHADOW_SRC = 1'b1
    } src_e;

endpackage

// File: rtl/ntm_exact_mul.sv
module ntm_exact_mul #(
    parameter int OP_W = 12
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] p
);
    localparam int PW = 2 * OP_W;

    // Row-by-row accumulation of shifted partial-product rows.
    logic [PW-1:0] acc [0:OP_W];

    assign acc[0] = '0;

    for (genvar i = 0; i < OP_W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row        = ({PW{a[i]}} & {{OP_W{1'b0}}, b}) << i;
        assign acc[i + 1] = acc[i] + row;
    end

    assign p = acc[OP_W];

endmodule

// File: rtl/ntm_shadow_mul.sv
module ntm_shadow_mul #(
    parameter int HW      = 6,
    parameter bit COMP_EN = 1'b1
) (
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    output logic [HW-1:0] q
);
    localparam int          CW   = HW + 3;
    localparam logic [CW-1:0] MAXV = CW'((1 << HW) - 1);

    logic [CW-1:0] kept;
    logic [CW-1:0] beta;
    logic [CW-1:0] total;

    // Keep only the upper columns of the array. The column just below them
    // is counted and injected at unit weight as a truncation bias.
    always_comb begin
        kept = '0;
        beta = '0;
        for (int i = 0; i < HW; i++) begin
            for (int j = 0; j < HW; j++) begin
                if (a[i] && b[j]) begin
                    if (i + j >= HW)
                        kept = kept + (CW'(1) << (i + j - HW));
                    else if (i + j == HW - 1)
                        beta = beta + CW'(1);
                end
            end
        end
    end

    if (COMP_EN) begin : g_comp
        assign total = kept + beta;
    end else begin : g_nocomp
        assign total = kept;
    end

    assign q = (total > MAXV) ? MAXV[HW-1:0] : total[HW-1:0];

endmodule

// File: rtl/ntm_judge.sv
module ntm_judge
    import ntm_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic [PW-1:0] main_v,
    input  logic [PW-1:0] shadow_v,
    input  logic [PW-1:0] tol,
    output logic [PW-1:0] mag,
    output src_e          sel
);
    logic main_ge;

    assign main_ge = (main_v >= shadow_v);
    assign mag     = main_ge ? (main_v - shadow_v) : (shadow_v - main_v);

    always_comb begin
        if (mag > tol) sel = SHADOW_SRC;
        else           sel = MAIN_SRC;
    end

endmodule

// File: rtl/noise_tolerant_mul.sv
module noise_tolerant_mul
    import ntm_pkg::*;
#(
    parameter int OP_W    = OP_W_DEFAULT,
    parameter int REP_W   = REP_W_DEFAULT,
    parameter bit COMP_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OP_W-1:0]      op_a,
    input  logic [OP_W-1:0]      op_b,
    input  logic [2*OP_W-1:0]    thresh,
    input  logic [2*OP_W-1:0]    dbg_mask,
    output logic [2*OP_W-1:0]    prod,
    output logic                 rep_used
);
    localparam int PW    = 2 * OP_W;
    localparam int SHIFT = 2 * (OP_W - REP_W) + REP_W;

    logic [OP_W-1:0] a_q;
    logic [OP_W-1:0] b_q;
    logic [PW-1:0]   th_q;
    logic [PW-1:0]   mask_q;

    logic [PW-1:0]    main_raw;
    logic [PW-1:0]    main_masked;
    logic [REP_W-1:0] shadow_q;
    logic [PW-1:0]    shadow_al;
    logic [PW-1:0]    abs_diff;
    src_e             pick;

    logic [PW-1:0]    prod_q;
    logic             used_q;

    // Stage 1: capture operands, threshold and mask.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            th_q   <= '0;
            mask_q <= '0;
        end else begin
            a_q    <= op_a;
            b_q    <= op_b;
            th_q   <= thresh;
            mask_q <= dbg_mask;
        end
    end

    ntm_exact_mul #(.OP_W(OP_W)) u_main (
        .a (a_q),
        .b (b_q),
        .p (main_raw)
    );

    ntm_shadow_mul #(.HW(REP_W), .COMP_EN(COMP_EN)) u_shadow (
        .a (a_q[OP_W-1 -: REP_W]),
        .b (b_q[OP_W-1 -: REP_W]),
        .q (shadow_q)
    );

    assign main_masked = main_raw ^ mask_q;
    assign shadow_al   = PW'(shadow_q) << SHIFT;

    ntm_judge #(.PW(PW)) u_judge (
        .main_v   (main_masked),
        .shadow_v (shadow_al),
        .tol      (th_q),
        .mag      (abs_diff),
        .sel      (pick)
    );

    // Stage 2: register the chosen source.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            used_q <= 1'b0;
        end else begin
            unique case (pick)
                MAIN_SRC: begin
                    prod_q <= main_masked;
                    used_q <= 1'b0;
                end
                SHADOW_SRC: begin
                    prod_q <= shadow_al;
                    used_q <= 1'b1;
                end
                default: begin
                    prod_q <= main_masked;
                    used_q <= 1'b0;
                end
            endcase
        end
    end

    assign prod     = prod_q;
    assign rep_used = used_q;

endmodule

// File: rtl/ntm_checker.sv
module ntm_checker #(
    parameter int PW    = 24,
    parameter int SHIFT = 18
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] prod,
    input logic          rep_used,
    input logic [PW-1:0] masked_main,
    input logic [PW-1:0] diff,
    input logic [PW-1:0] th_q
);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prod == '0 && !rep_used));

    assert_shadow_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rep_used |-> (prod[SHIFT-1:0] == '0));

    assert_main_within_tol_R5: assert property (@(posedge clk) disable iff (rst)
        (!rep_used && !$past(rst)) |-> ($past(diff) <= $past(th_q)));

    assert_main_value_R6: assert property (@(posedge clk) disable iff (rst)
        (!rep_used && !$past(rst)) |-> (prod == $past(masked_main)));

    assert_flag_over_tol_R8: assert property (@(posedge clk) disable iff (rst)
        rep_used |-> ($past(diff) > $past(th_q)));

endmodule

bind noise_tolerant_mul ntm_checker #(.PW(PW), .SHIFT(SHIFT)) u_ntm_checker (
    .clk         (clk),
    .rst         (rst),
    .prod        (prod),
    .rep_used    (rep_used),
    .masked_main (main_masked),
    .diff        (abs_diff),
    .th_q        (th_q)
);

// File: tb/test_noise_tolerant_mul.sv
module test_noise_tolerant_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic [23:0] thresh = '0;
    logic [23:0] dbg_mask = '0;
    logic [23:0] prod;
    logic        rep_used;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    noise_tolerant_mul i_noise_tolerant_mul (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .thresh   (thresh),
        .dbg_mask (dbg_mask),
        .prod     (prod),
        .rep_used (rep_used)
    );

    // Aligned estimate per R3.
    function automatic logic [23:0] ref_est(logic [11:0] x, logic [11:0] y);
        int kept = 0;
        int beta = 0;
        int t;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                if (x[6+i] && y[6+j]) begin
                    if (i + j >= 6) kept += (1 << (i + j - 6));
                    else if (i + j == 5) beta += 1;
                end
            end
        end
        t = kept + beta;
        if (t > 63) t = 63;
        return 24'(t) << 18;
    endfunction

    function automatic logic [23:0] ref_mag(logic [11:0] x, logic [11:0] y, logic [23:0] m);
        logic [23:0] mv;
        logic [23:0] ev;
        mv = (24'(x) * 24'(y)) ^ m;
        ev = ref_est(x, y);
        return (mv > ev) ? mv - ev : ev - mv;
    endfunction

    function automatic logic [24:0] ref_out(logic [11:0] x, logic [11:0] y,
                                            logic [23:0] th, logic [23:0] m);
        logic [23:0] mv;
        mv = (24'(x) * 24'(y)) ^ m;
        if (ref_mag(x, y, m) > th) return {1'b1, ref_est(x, y)};
        return {1'b0, mv};
    endfunction

    task automatic check(string tag, logic [24:0] got, logic [24:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got flag=%0d prod=%h, expected flag=%0d prod=%h",
                     tag, got[24], got[23:0], exp[24], exp[23:0]);
        end
    endtask

    task automatic apply_one(logic [11:0] x, logic [11:0] y,
                             logic [23:0] th, logic [23:0] m, string tag);
        @(negedge clk);
        op_a = x; op_b = y; thresh = th; dbg_mask = m;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(tag, {rep_used, prod}, ref_out(x, y, th, m));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset state", {rep_used, prod}, 25'd0);
        rst = 1'b0;
    endtask

    task automatic t_exact();
        apply_one(12'hFFF, 12'hFFF, 24'hFFFFFF, 24'd0, "R2 max operands");
        check("R2 exact value", {rep_used, prod}, {1'b0, 24'd16769025});
        apply_one(12'h001, 12'hABC, 24'hFFFFFF, 24'd0, "R2 unit operand");
        apply_one(12'h000, 12'h7FF, 24'hFFFFFF, 24'd0, "R2 zero operand");
        apply_one(12'h5A5, 12'h3C3, 24'hFFFFFF, 24'd0, "R2 mixed bits");
    endtask

    task automatic t_estimate();
        apply_one(12'hFFF, 12'hFFF, 24'd0, 24'd0, "R3 estimate full ones");
        check("R3 estimate saturated value", {rep_used, prod}, {1'b1, 24'd16515072});
        apply_one(12'hABC, 12'h123, 24'd0, 24'd0, "R3 estimate mixed");
        apply_one(12'h840, 12'h840, 24'd0, 24'd0, "R3 estimate sparse");
    endtask

    task automatic t_direction_and_bounds();
        logic [23:0] d;
        // Main above the estimate.
        d = ref_mag(12'hFFF, 12'hFFF, 24'd0);
        apply_one(12'hFFF, 12'hFFF, d, 24'd0, "R5 equal tolerance keeps main (main above)");
        apply_one(12'hFFF, 12'hFFF, d - 24'd1, 24'd0, "R4 R5 one over selects estimate (main above)");
        // Main below the estimate.
        d = ref_mag(12'hFC0, 12'hFC0, 24'd0);
        check("R4 magnitude when main below", {1'b0, d}, {1'b0, 24'd258048});
        apply_one(12'hFC0, 12'hFC0, d, 24'd0, "R4 R5 equal tolerance keeps main (main below)");
        apply_one(12'hFC0, 12'hFC0, d - 24'd1, 24'd0, "R4 R8 one over selects estimate (main below)");
    endtask

    task automatic t_mask();
        apply_one(12'h321, 12'h654, 24'hFFFFFF, 24'h000F0F, "R6 mask passes through main");
        apply_one(12'h321, 12'h654, 24'h001000, 24'hF00000, "R6 R8 large mask triggers estimate");
        apply_one(12'h321, 12'h654, 24'h100000, 24'h000001, "R6 small mask stays within tolerance");
    endtask

    task automatic t_lowbits();
        logic [24:0] first;
        apply_one(12'hA80, 12'h9C0, 24'd0, 24'hFFFFFF, "R9 low bits clear");
        first = {rep_used, prod};
        apply_one(12'hABF, 12'h9FF, 24'd0, 24'hFFFFFF, "R9 low bits set");
        check("R9 estimate unchanged by low bits", {rep_used, prod}, first);
    endtask

    task automatic t_stream();
        logic [11:0] xs [0:7];
        logic [11:0] ys [0:7];
        logic [23:0] ts [0:7];
        for (int k = 0; k < 8; k++) begin
            xs[k] = 12'(k * 517 + 91);
            ys[k] = 12'(4095 - k * 333);
            ts[k] = (k % 2 == 0) ? 24'd0 : 24'hFFFFFF;
        end
        for (int m = 0; m < 10; m++) begin
            @(negedge clk);
            if (m >= 2)
                check("R7 back-to-back latency", {rep_used, prod},
                      ref_out(xs[m-2], ys[m-2], ts[m-2], 24'd0));
            if (m < 8) begin
                op_a = xs[m]; op_b = ys[m]; thresh = ts[m]; dbg_mask = '0;
            end
        end
    endtask

    task automatic t_midreset();
        apply_one(12'hFFF, 12'h800, 24'd0, 24'd0, "R8 flag before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset clears", {rep_used, prod}, 25'd0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_exact();
        t_estimate();
        t_direction_and_bounds();
        t_mask();
        t_lowbits();
        t_stream();
        t_midreset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule